// File: doc/BRIEF.md
# Dual-Rail Startup and Hiccup Sequencer

This block supervises two supply rails that come from one input supply: a switching (buck) rail and a linear rail. It keeps both rails off while the shared supply is too low or while an external shutdown request is active. Once released, it gives each rail its own digital soft-start code that rises by a fixed step on every switching-cycle tick and stops at full scale. The codes feed reference DACs, and the enables drive the gate drivers and the linear pass-device output.

Two kinds of fault put both rails into a common off period, called hiccup. One is an overcurrent flag from the switching rail. The other is a linear-rail feedback-low flag that has stayed high for a qualification window. The feedback-low flag is not watched while the linear rail is still ramping, so its feedback can follow the rising reference. After a fixed number of cycle ticks in hiccup, both ramps start again from zero. Supply loss and shutdown take priority over everything else.

Top module: `dualrail_startup_seq`

## Requirements
- R1: While reset is active, and in the cycle after any clock edge that samples `supply_uv_i` high, both enables, both soft-start codes, both done flags and `hiccup_o` are zero.
- R2: When an edge samples `supply_uv_i` and `shutdown_req_i` both low with the block off, both enables are high after that edge. Each code then rises by its step (default 1) at every edge that samples `cycle_tick_i` high and holds at edges where it is low. Each code saturates at 2047 (11-bit full scale).
- R3: Each channel's done flag is high exactly when that channel's code equals 2047. With step 1 and a tick on every edge, this happens 2047 edges after the ramp starts.
- R4: An edge that samples `shutdown_req_i` high turns off both enables, zeroes both codes and clears `hiccup_o`. This holds in every state, including hiccup and the same cycle as an overcurrent. After release, the ramps restart from zero at the next edge.
- R5: When a running block samples `sw_overcurrent_i` high, the next edge enters hiccup: `hiccup_o` is high, both enables are low and both codes are zero.
- R6: After the linear ramp is done, `lin_fb_low_i` must be held high for QUAL_TICKS (default 16) consecutive ticks to enter hiccup. Hiccup starts one edge after the count completes. A shorter pulse resets the count and has no effect.
- R7: `lin_fb_low_i` has no effect while the linear ramp has not reached full scale.
- R8: Hiccup lasts HICCUP_TICKS (default 2048) ticks. At the edge that samples the last tick, the block returns to running with both codes restarting from their first step.
- R9: Supply undervoltage overrides hiccup, including at the edge where hiccup would expire. The block goes off, and when the supply returns it restarts at once without finishing the hiccup time.
- R10: An overcurrent flag seen during hiccup neither extends nor restarts the hiccup period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_uv_i | input | 1 | Synchronized shared-supply undervoltage flag |
| shutdown_req_i | input | 1 | Shutdown request from the error-amplifier pin comparator |
| sw_overcurrent_i | input | 1 | Switching-rail overcurrent comparator flag |
| lin_fb_low_i | input | 1 | Linear-rail feedback undervoltage comparator flag |
| cycle_tick_i | input | 1 | One-clock pulse per switching cycle |
| sw_ss_code_o | output | 11 | Switching-rail soft-start reference code |
| lin_ss_code_o | output | 11 | Linear-rail soft-start reference code |
| sw_ss_done_o | output | 1 | Switching-rail ramp at full scale |
| lin_ss_done_o | output | 1 | Linear-rail ramp at full scale |
| sw_drv_en_o | output | 1 | Enable for the switching gate drivers |
| lin_out_en_o | output | 1 | Enable for the linear output |
| hiccup_o | output | 1 | Block is in the hiccup off period |

## Verification
The collision of interest is hiccup expiry and a supply drop arriving at the same clock edge. The bench raises `supply_uv_i` in the cycle before the 2048th hiccup tick is sampled. It then expects the block to be off, not running, after that edge, with the hiccup flag, both enables and both codes at zero. A second collision applies shutdown and overcurrent together on a running block and expects the off state with no hiccup. The supply-return and shutdown-release cycles that follow show that restart happens on the next edge.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        SEQ_OFF    = 2'd0,
        SEQ_RUN    = 2'd1,
        SEQ_HICCUP = 2'd2
    } seq_state_e;

    localparam int NUM_CH = 2;
    localparam int CH_SW  = 0;
    localparam int CH_LIN = 1;

endpackage

// File: rtl/ss_ramp.sv
module ss_ramp #(
    parameter int CODE_W = 11,
    parameter int STEP   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              tick_i,
    output logic [CODE_W-1:0] code_o,
    output logic              done_o
);

    localparam logic [CODE_W:0]   FULL_EXT = {1'b0, {CODE_W{1'b1}}};
    localparam logic [CODE_W-1:0] FULL     = {CODE_W{1'b1}};
    localparam logic [CODE_W:0]   STEP_EXT = (CODE_W+1)'(STEP);

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } ramp_regs_t;

    ramp_regs_t    regs_d, regs_q;
    logic [CODE_W:0] sum;

    always_comb begin
        regs_d = regs_q;
        sum    = {1'b0, regs_q.code} + STEP_EXT;
        if (!run_i) begin
            regs_d.code = '0;
        end else if (tick_i) begin
            if (sum > FULL_EXT) begin
                regs_d.code = FULL;
            end else begin
                regs_d.code = sum[CODE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign code_o = regs_q.code;
    assign done_o = (regs_q.code == FULL);

endmodule

// File: rtl/fault_qualifier.sv
module fault_qualifier #(
    parameter int QUAL_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic flag_i,
    input  logic tick_i,
    output logic fault_o
);

    localparam int CNT_W = (QUAL_TICKS > 1) ? $clog2(QUAL_TICKS + 1) : 1;
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(QUAL_TICKS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } qual_regs_t;

    qual_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (!arm_i || !flag_i) begin
            regs_d.cnt = '0;
        end else if (tick_i && (regs_q.cnt < LIMIT)) begin
            regs_d.cnt = regs_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign fault_o = arm_i && (regs_q.cnt == LIMIT);

endmodule

// File: rtl/hiccup_timer.sv
module hiccup_timer #(
    parameter int HICCUP_TICKS = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic tick_i,
    output logic expire_o
);

    localparam int CNT_W = (HICCUP_TICKS > 1) ? $clog2(HICCUP_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HICCUP_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (!active_i) begin
            regs_d.cnt = '0;
        end else if (tick_i && (regs_q.cnt != LAST)) begin
            regs_d.cnt = regs_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign expire_o = active_i && tick_i && (regs_q.cnt == LAST);

endmodule

// File: rtl/dualrail_startup_seq.sv
module dualrail_startup_seq
    import seq_pkg::*;
#(
    parameter int CODE_W       = 11,
    parameter int SW_STEP      = 1,
    parameter int LIN_STEP     = 1,
    parameter int QUAL_TICKS   = 16,
    parameter int HICCUP_TICKS = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supply_uv_i,
    input  logic              shutdown_req_i,
    input  logic              sw_overcurrent_i,
    input  logic              lin_fb_low_i,
    input  logic              cycle_tick_i,
    output logic [CODE_W-1:0] sw_ss_code_o,
    output logic [CODE_W-1:0] lin_ss_code_o,
    output logic              sw_ss_done_o,
    output logic              lin_ss_done_o,
    output logic              sw_drv_en_o,
    output logic              lin_out_en_o,
    output logic              hiccup_o
);

    typedef struct packed {
        seq_state_e state;
    } seq_regs_t;

    seq_regs_t         regs_d, regs_q;
    logic [CODE_W-1:0] ss_code [NUM_CH];
    logic [NUM_CH-1:0] ss_done;
    logic              force_off;
    logic              lin_fault;
    logic              hic_expire;
    logic              run_next;

    // Priority: supply loss / shutdown, then faults, then normal run.
    always_comb begin
        regs_d    = regs_q;
        force_off = supply_uv_i || shutdown_req_i;
        if (force_off) begin
            regs_d.state = SEQ_OFF;
        end else begin
            unique case (regs_q.state)
                SEQ_OFF: begin
                    regs_d.state = SEQ_RUN;
                end
                SEQ_RUN: begin
                    if (sw_overcurrent_i || lin_fault) begin
                        regs_d.state = SEQ_HICCUP;
                    end
                end
                SEQ_HICCUP: begin
                    if (hic_expire) begin
                        regs_d.state = SEQ_RUN;
                    end
                end
                default: begin
                    regs_d.state = SEQ_OFF;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= SEQ_OFF;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign run_next = (regs_d.state == SEQ_RUN);

    // One independent ramp per channel, each with its own step size.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ramp
        localparam int STEP = (ch == CH_SW) ? SW_STEP : LIN_STEP;
        ss_ramp #(
            .CODE_W (CODE_W),
            .STEP   (STEP)
        ) u_ramp (
            .clk    (clk),
            .rst_n  (rst_n),
            .run_i  (run_next),
            .tick_i (cycle_tick_i),
            .code_o (ss_code[ch]),
            .done_o (ss_done[ch])
        );
    end

    // Linear feedback-low watch is armed only after its ramp has finished.
    fault_qualifier #(
        .QUAL_TICKS (QUAL_TICKS)
    ) u_lin_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   ((regs_q.state == SEQ_RUN) && ss_done[CH_LIN]),
        .flag_i  (lin_fb_low_i),
        .tick_i  (cycle_tick_i),
        .fault_o (lin_fault)
    );

    hiccup_timer #(
        .HICCUP_TICKS (HICCUP_TICKS)
    ) u_hic_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (regs_q.state == SEQ_HICCUP),
        .tick_i   (cycle_tick_i),
        .expire_o (hic_expire)
    );

    assign sw_ss_code_o  = ss_code[CH_SW];
    assign lin_ss_code_o = ss_code[CH_LIN];
    assign sw_ss_done_o  = ss_done[CH_SW];
    assign lin_ss_done_o = ss_done[CH_LIN];
    assign sw_drv_en_o   = (regs_q.state == SEQ_RUN);
    assign lin_out_en_o  = (regs_q.state == SEQ_RUN);
    assign hiccup_o      = (regs_q.state == SEQ_HICCUP);

endmodule

// File: rtl/dualrail_startup_seq_chk.sv
module dualrail_startup_seq_chk #(
    parameter int CODE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              supply_uv_i,
    input logic              shutdown_req_i,
    input logic              sw_overcurrent_i,
    input logic              cycle_tick_i,
    input logic [CODE_W-1:0] sw_ss_code_o,
    input logic [CODE_W-1:0] lin_ss_code_o,
    input logic              sw_ss_done_o,
    input logic              lin_ss_done_o,
    input logic              sw_drv_en_o,
    input logic              lin_out_en_o,
    input logic              hiccup_o
);

    // R1
    a_r1_uv_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        supply_uv_i |=> (!sw_drv_en_o && !lin_out_en_o && !hiccup_o &&
                         sw_ss_code_o == '0 && lin_ss_code_o == '0));

    // R2
    a_r2_code_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
        sw_drv_en_o |=> (!sw_drv_en_o || sw_ss_code_o >= $past(sw_ss_code_o)));

    // R2
    a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_out_en_o && !cycle_tick_i) |=> (!lin_out_en_o || $stable(lin_ss_code_o)));

    // R3
    a_r3_done_at_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_ss_done_o) |-> (sw_ss_code_o == '1));

    // R4
    a_r4_shutdown_off: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_req_i |=> (!sw_drv_en_o && !lin_out_en_o && !hiccup_o));

    // R5
    a_r5_oc_enters_hiccup: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_drv_en_o && sw_overcurrent_i && !supply_uv_i && !shutdown_req_i) |=> hiccup_o);

    // R7
    a_r7_no_lin_fault_in_ramp: assert property (@(posedge clk) disable iff (!rst_n)
        (lin_out_en_o && !lin_ss_done_o && !sw_overcurrent_i) |=> !hiccup_o);

    // R8
    a_r8_hiccup_rails_off: assert property (@(posedge clk) disable iff (!rst_n)
        hiccup_o |-> (!sw_drv_en_o && !lin_out_en_o &&
                      sw_ss_code_o == '0 && lin_ss_code_o == '0));

endmodule

bind dualrail_startup_seq dualrail_startup_seq_chk #(
    .CODE_W (CODE_W)
) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .supply_uv_i      (supply_uv_i),
    .shutdown_req_i   (shutdown_req_i),
    .sw_overcurrent_i (sw_overcurrent_i),
    .cycle_tick_i     (cycle_tick_i),
    .sw_ss_code_o     (sw_ss_code_o),
    .lin_ss_code_o    (lin_ss_code_o),
    .sw_ss_done_o     (sw_ss_done_o),
    .lin_ss_done_o    (lin_ss_done_o),
    .sw_drv_en_o      (sw_drv_en_o),
    .lin_out_en_o     (lin_out_en_o),
    .hiccup_o         (hiccup_o)
);

// File: tb/dualrail_startup_seq_tb.sv
`timescale 1ns/1ps
module dualrail_startup_seq_tb;

    localparam int F_SWC = 0, F_LNC = 1, F_SWE = 2, F_LNE = 3,
                   F_HIC = 4, F_SWD = 5, F_LND = 6;

    typedef struct {
        int    at;
        int    fld;
        int    val;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n, uv, shdn, oc, lfb, tick;
    logic [10:0] sw_code, lin_code;
    logic        sw_done, lin_done, sw_en, lin_en, hic;

    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dualrail_startup_seq u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .supply_uv_i      (uv),
        .shutdown_req_i   (shdn),
        .sw_overcurrent_i (oc),
        .lin_fb_low_i     (lfb),
        .cycle_tick_i     (tick),
        .sw_ss_code_o     (sw_code),
        .lin_ss_code_o    (lin_code),
        .sw_ss_done_o     (sw_done),
        .lin_ss_done_o    (lin_done),
        .sw_drv_en_o      (sw_en),
        .lin_out_en_o     (lin_en),
        .hiccup_o         (hic)
    );

    function automatic int actual(int fld);
        case (fld)
            F_SWC:   return int'(sw_code);
            F_LNC:   return int'(lin_code);
            F_SWE:   return int'(sw_en);
            F_LNE:   return int'(lin_en);
            F_HIC:   return int'(hic);
            F_SWD:   return int'(sw_done);
            default: return int'(lin_done);
        endcase
    endfunction

    function automatic void expect_v(int at, int fld, int val, string req);
        exp_t e;
        e.at = at; e.fld = fld; e.val = val; e.req = req;
        sb_q.push_back(e);
    endfunction

    // Monitor: compare every expected item due in this cycle.
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].at <= cyc) begin
                n_cmp++;
                if (actual(sb_q[i].fld) != sb_q[i].val) begin
                    n_bad++;
                    $display("FAIL %s cycle %0d field %0d: actual %0d expected %0d",
                             sb_q[i].req, cyc, sb_q[i].fld, actual(sb_q[i].fld), sb_q[i].val);
                end
                sb_q.delete(i);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) step(1);
    endtask

    initial begin
        int s, c, c2, h, r0, h2, u, o, h3, u2, t, z;
        rst_n = 1'b0; uv = 1'b1; shdn = 1'b0; oc = 1'b0; lfb = 1'b0; tick = 1'b1;
        step(3);
        expect_v(cyc, F_SWE, 0, "R1 reset");
        expect_v(cyc, F_SWC, 0, "R1 reset");
        expect_v(cyc, F_HIC, 0, "R1 reset");
        rst_n = 1'b1;
        step(5);
        expect_v(cyc + 1, F_SWE, 0, "R1 uv held");
        expect_v(cyc + 1, F_LNE, 0, "R1 uv held");
        expect_v(cyc + 1, F_LNC, 0, "R1 uv held");
        step(10);

        // R2 / R3: full ramp from supply release
        s = cyc; uv = 1'b0;
        expect_v(s + 1, F_SWE, 1, "R2 enable");
        expect_v(s + 1, F_LNE, 1, "R2 enable");
        expect_v(s + 1, F_SWC, 1, "R2 first step");
        expect_v(s + 1, F_LNC, 1, "R2 first step");
        expect_v(s + 1000, F_SWC, 1000, "R2 ramp");
        expect_v(s + 2046, F_SWD, 0, "R3 not yet done");
        expect_v(s + 2046, F_LND, 0, "R3 not yet done");
        expect_v(s + 2047, F_SWD, 1, "R3 done");
        expect_v(s + 2047, F_LND, 1, "R3 done");
        expect_v(s + 2047, F_SWC, 2047, "R3 full");
        expect_v(s + 2100, F_SWC, 2047, "R2 saturate");
        expect_v(s + 2100, F_LNC, 2047, "R2 saturate");
        wait_to(s + 2110);

        // R6: short feedback-low pulse has no effect
        c = cyc; lfb = 1'b1;
        expect_v(c + 20, F_HIC, 0, "R6 short pulse");
        expect_v(c + 20, F_LNE, 1, "R6 short pulse");
        step(15); lfb = 1'b0;
        wait_to(c + 40);

        // R6: qualified feedback-low enters hiccup
        c2 = cyc; lfb = 1'b1;
        expect_v(c2 + 16, F_HIC, 0, "R6 before window");
        expect_v(c2 + 17, F_HIC, 1, "R6 hiccup");
        expect_v(c2 + 17, F_SWE, 0, "R6 hiccup");
        expect_v(c2 + 17, F_LNE, 0, "R6 hiccup");
        expect_v(c2 + 17, F_SWC, 0, "R6 hiccup");
        expect_v(c2 + 17, F_LNC, 0, "R6 hiccup");
        step(17); lfb = 1'b0;
        h = c2 + 17;
        expect_v(h + 2047, F_HIC, 1, "R8 R10 still off");
        expect_v(h + 2048, F_HIC, 0, "R8 expiry");
        expect_v(h + 2048, F_SWE, 1, "R8 restart");
        expect_v(h + 2048, F_SWC, 1, "R8 restart code");
        wait_to(h + 100);
        oc = 1'b1; step(1); oc = 1'b0;

        // R7: feedback-low ignored during linear ramp
        r0 = h + 2048;
        wait_to(r0 + 5); lfb = 1'b1;
        expect_v(r0 + 2000, F_HIC, 0, "R7 blanked");
        expect_v(r0 + 2000, F_LNE, 1, "R7 blanked");
        expect_v(r0 + 2046, F_LND, 1, "R7 done");
        expect_v(r0 + 2062, F_HIC, 0, "R6 after done");
        expect_v(r0 + 2063, F_HIC, 1, "R6 after done");
        h2 = r0 + 2063;
        wait_to(h2 + 1); lfb = 1'b0;

        // R9: supply loss during hiccup
        wait_to(h2 + 500);
        expect_v(cyc, F_HIC, 1, "R9 in hiccup");
        uv = 1'b1;
        expect_v(h2 + 501, F_HIC, 0, "R9 uv wins");
        expect_v(h2 + 501, F_SWE, 0, "R9 uv wins");
        wait_to(h2 + 600);
        u = cyc; uv = 1'b0;
        expect_v(u + 1, F_SWE, 1, "R9 immediate restart");
        expect_v(u + 1, F_SWC, 1, "R9 immediate restart");
        expect_v(u + 1, F_HIC, 0, "R9 immediate restart");

        // R5: overcurrent
        wait_to(u + 50);
        o = cyc;
        expect_v(o, F_HIC, 0, "R5 before");
        oc = 1'b1; step(1); oc = 1'b0;
        expect_v(o + 1, F_HIC, 1, "R5 hiccup");
        expect_v(o + 1, F_SWE, 0, "R5 hiccup");
        expect_v(o + 1, F_SWC, 0, "R5 hiccup");
        expect_v(o + 1, F_LNC, 0, "R5 hiccup");
        h3 = o + 1;

        // R9: supply loss on the expiry edge
        wait_to(h3 + 2047);
        expect_v(cyc, F_HIC, 1, "R9 last hiccup cycle");
        uv = 1'b1;
        expect_v(h3 + 2048, F_HIC, 0, "R9 same edge");
        expect_v(h3 + 2048, F_SWE, 0, "R9 same edge");
        expect_v(h3 + 2048, F_SWC, 0, "R9 same edge");
        wait_to(h3 + 2060); uv = 1'b0;
        expect_v(h3 + 2061, F_SWE, 1, "R9 resume");
        expect_v(h3 + 2061, F_SWC, 1, "R9 resume");
        u2 = h3 + 2061;

        // R2: tick gating
        wait_to(u2 + 99);
        t = cyc;
        expect_v(t, F_SWC, 100, "R2 before gap");
        tick = 1'b0;
        expect_v(t + 5, F_SWC, 100, "R2 no tick hold");
        expect_v(t + 10, F_SWC, 100, "R2 no tick hold");
        expect_v(t + 10, F_LNC, 100, "R2 no tick hold");
        wait_to(t + 10); tick = 1'b1;
        expect_v(t + 11, F_SWC, 101, "R2 resume step");

        // R4: shutdown while running
        wait_to(t + 50);
        z = cyc;
        expect_v(z, F_SWC, 140, "R2 ramp value");
        shdn = 1'b1;
        expect_v(z + 1, F_SWC, 0, "R4 shutdown");
        expect_v(z + 1, F_SWE, 0, "R4 shutdown");
        expect_v(z + 1, F_LNE, 0, "R4 shutdown");
        expect_v(z + 5, F_LNC, 0, "R4 shutdown");
        wait_to(z + 10); shdn = 1'b0;
        expect_v(z + 11, F_SWC, 1, "R4 restart");
        expect_v(z + 11, F_SWE, 1, "R4 restart");

        // R4: shutdown during hiccup
        wait_to(z + 30);
        oc = 1'b1; step(1); oc = 1'b0;
        expect_v(z + 31, F_HIC, 1, "R5 hiccup again");
        wait_to(z + 40); shdn = 1'b1;
        expect_v(z + 41, F_HIC, 0, "R4 shutdown in hiccup");
        expect_v(z + 41, F_SWE, 0, "R4 shutdown in hiccup");
        wait_to(z + 45); shdn = 1'b0;
        expect_v(z + 46, F_SWE, 1, "R4 restart after hiccup");
        expect_v(z + 46, F_SWC, 1, "R4 restart after hiccup");
        expect_v(z + 46, F_HIC, 0, "R4 restart after hiccup");

        // R4: shutdown and overcurrent on the same edge
        wait_to(z + 100);
        oc = 1'b1; shdn = 1'b1;
        expect_v(z + 101, F_HIC, 0, "R4 shutdown beats oc");
        expect_v(z + 101, F_SWE, 0, "R4 shutdown beats oc");
        step(1); oc = 1'b0; shdn = 1'b0;
        expect_v(z + 102, F_SWE, 1, "R4 release");
        expect_v(z + 102, F_HIC, 0, "R4 release");

        wait_to(z + 110);
        while (sb_q.size() > 0) step(1);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule